// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Slave

This block connects a narrow serial management link to a parallel register port. A master raises a request line and, while it is high, presents two bits per clock on a 2-bit input. The first nine pairs carry a 17-bit register address. Each pair is ordered least significant first, and the first pair pads the address with a constant zero. The length of the request decides the access type. If the request is held for the address alone, the access is a read. If it is held for the address plus a full payload, the access is a write, and the payload follows the address in the same pair order.

On a write, the slave presents the address and data on the parallel port with a single-cycle write strobe. One cycle later it answers with a single-cycle acknowledge. On a read, it issues a single-cycle read strobe and captures the returned word. It then holds the acknowledge high while it shifts the word out two bits per cycle, lowest pair first. The payload width is fixed at build time to 32 or 8 bits, so a write request is 25 or 13 cycles long.

Dropping the request before an access is complete cancels it. The slave returns to idle without touching the register port.

Top module: `pair_serial_reg_slave`

## Requirements
- R1: After reset, `ack_o`, `sdo_o`, `reg_we_o` and `reg_re_o` are all 0.
- R2: The address is taken over 9 request cycles. Cycle 0 carries `sdi_i[1]`=A0 and `sdi_i[0]`=0. Cycle k≥1 carries `sdi_i[1]`=A(2k) and `sdi_i[0]`=A(2k-1). `reg_addr_o` equals the 17-bit address during every strobe.
- R3: A request high for exactly 9 cycles (cycles 0..8) is a read. `reg_re_o` is high for one cycle, the cycle after the request is first sampled low.
- R4: On a read, `ack_o` goes high the cycle after the read strobe and stays high for DATA_W/2 consecutive cycles. In cycle j of that window, `sdo_o[1]`=D(2j+1) and `sdo_o[0]`=D(2j) of the word present on `reg_rdata_i` during the strobe.
- R5: A request high for 9+DATA_W/2 cycles (25 for 32-bit, 13 for 8-bit) is a write. Data cycle j carries `sdi_i[1]`=D(2j+1) and `sdi_i[0]`=D(2j). `reg_we_o` pulses once, in the cycle after the last pair is sampled, with `reg_wdata_o` equal to the payload.
- R6: On a write, `ack_o` is high for exactly one cycle, the cycle after the write strobe.
- R7: A request that falls before the ninth address pair, or during the payload before its last pair, causes no strobe and no acknowledge. The slave is then idle.
- R8: `sdo_o` is 00 in every cycle in which `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Serial request; its length sets access type |
| sdi_i | input | 2 | Serial address/write data, two bits per cycle |
| ack_o | output | 1 | Serial acknowledge |
| sdo_o | output | 2 | Serial read data, two bits per cycle |
| reg_addr_o | output | ADDR_W | Parallel register address |
| reg_wdata_o | output | DATA_W | Parallel write data |
| reg_we_o | output | 1 | Parallel write strobe, one cycle |
| reg_re_o | output | 1 | Parallel read strobe, one cycle |
| reg_rdata_i | input | DATA_W | Parallel read data, sampled during the read strobe |

## Verification
Two events share one clock edge: the edge after the ninth address pair. On that edge the slave either decides that the access is a read, because the request has fallen, or captures the first payload pair, because the request is still high. A fall one cycle earlier or later is an abort instead. The bench therefore drives requests of every length from 1 to 9+DATA_W/2 cycles on both widths. For each length it judges the outcome by counting strobes and acknowledge cycles, and by reading the target register back afterwards. Read and write strobe positions are compared against cycle indices computed from the request length.

// File: rtl/s2b_pkg.sv
package s2b_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_TURN,
      ST_DATA,
      ST_RSTB,
      ST_ROUT,
      ST_WSTB,
      ST_WACK
   } s2b_state_e;
endpackage

// File: rtl/s2b_pair_shreg.sv
module s2b_pair_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         load_i,
   input  logic [1:0]   pair_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] q_o
);
   localparam int STAGES = W / 2;

   logic [W-1:0] q;

   generate
      if ((W % 2) != 0 || W < 4) begin : g_bad_w
         $error("s2b_pair_shreg: W must be even and at least 4");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic [1:0] st;
         logic [1:0] nxt;
         if (g == STAGES - 1) begin : g_top
            assign nxt = pair_i;
         end else begin : g_mid
            assign nxt = q[2*g+2 +: 2];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       st <= 2'b00;
            else if (load_i)  st <= load_val_i[2*g +: 2];
            else if (shift_i) st <= nxt;
         end
         assign q[2*g +: 2] = st;
      end
   endgenerate

   assign q_o = q;
endmodule

// File: rtl/s2b_ctrl.sv
module s2b_ctrl
   import s2b_pkg::*;
#(
   parameter int ADDR_CYC = 9,
   parameter int DATA_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic addr_shift_o,
   output logic data_shift_o,
   output logic data_load_o,
   output logic we_o,
   output logic re_o,
   output logic ack_o
);
   localparam int MAXC  = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CYC - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_CYC - 1);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   s2b_state_e       state;
   logic [CNT_W-1:0] cnt;

   generate
      if (ADDR_CYC < 2 || DATA_CYC < 2) begin : g_bad_cyc
         $error("s2b_ctrl: address and data phases need at least 2 cycles");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_i) begin
               state <= ST_ADDR;
               cnt   <= ONE;
            end
            ST_ADDR: begin
               if (!req_i)                 state <= ST_IDLE;
               else if (cnt == ADDR_LAST) begin
                  state <= ST_TURN;
                  cnt   <= '0;
               end else                    cnt <= cnt + ONE;
            end
            ST_TURN: begin
               if (req_i) begin
                  state <= ST_DATA;
                  cnt   <= ONE;
               end else state <= ST_RSTB;
            end
            ST_DATA: begin
               if (!req_i)                 state <= ST_IDLE;
               else if (cnt == DATA_LAST)  state <= ST_WSTB;
               else                        cnt <= cnt + ONE;
            end
            ST_RSTB: begin
               state <= ST_ROUT;
               cnt   <= '0;
            end
            ST_ROUT: begin
               if (cnt == DATA_LAST) state <= ST_IDLE;
               else                  cnt <= cnt + ONE;
            end
            ST_WSTB: state <= ST_WACK;
            ST_WACK: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      addr_shift_o = req_i && (state == ST_IDLE || state == ST_ADDR);
      data_shift_o = (req_i && (state == ST_TURN || state == ST_DATA))
                     || (state == ST_ROUT);
      data_load_o  = (state == ST_RSTB);
      we_o         = (state == ST_WSTB);
      re_o         = (state == ST_RSTB);
      ack_o        = (state == ST_ROUT) || (state == ST_WACK);
   end

   // R7
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ADDR || state == ST_DATA) && !req_i)
      |=> (!we_o && !re_o && !ack_o));

   // R6
   wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |=> (ack_o && !we_o));

   // R4
   rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      re_o |=> (ack_o && !re_o));

   // R3
   rd_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TURN && !req_i) |=> re_o);
endmodule

// File: rtl/pair_serial_reg_slave.sv
module pair_serial_reg_slave #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [1:0]        sdi_i,
   output logic              ack_o,
   output logic [1:0]        sdo_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   output logic              reg_we_o,
   output logic              reg_re_o,
   input  logic [DATA_W-1:0] reg_rdata_i
);
   localparam int ADDR_CYC = (ADDR_W + 1) / 2;
   localparam int DATA_CYC = DATA_W / 2;
   localparam int ASR_W    = 2 * ADDR_CYC;

   generate
      if (DATA_W != 8 && DATA_W != 32) begin : g_bad_data_w
         $error("pair_serial_reg_slave: DATA_W must be 8 or 32");
      end
      if ((ADDR_W % 2) == 0) begin : g_bad_addr_w
         $error("pair_serial_reg_slave: ADDR_W must be odd (one pad bit)");
      end
   endgenerate

   logic              addr_shift, data_shift, data_load, ack;
   logic [ASR_W-1:0]  addr_q;
   logic [DATA_W-1:0] data_q;
   logic              pad_unused;

   s2b_ctrl #(
      .ADDR_CYC (ADDR_CYC),
      .DATA_CYC (DATA_CYC)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .addr_shift_o (addr_shift),
      .data_shift_o (data_shift),
      .data_load_o  (data_load),
      .we_o         (reg_we_o),
      .re_o         (reg_re_o),
      .ack_o        (ack)
   );

   s2b_pair_shreg #(.W(ASR_W)) addr_sr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (addr_shift),
      .load_i     (1'b0),
      .pair_i     (sdi_i),
      .load_val_i ({ASR_W{1'b0}}),
      .q_o        (addr_q)
   );

   s2b_pair_shreg #(.W(DATA_W)) data_sr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (data_shift),
      .load_i     (data_load),
      .pair_i     (sdi_i),
      .load_val_i (reg_rdata_i),
      .q_o        (data_q)
   );

   assign pad_unused  = addr_q[0];
   assign reg_addr_o  = addr_q[ASR_W-1:1];
   assign reg_wdata_o = data_q;
   assign ack_o       = ack;
   assign sdo_o       = ack ? data_q[1:0] : 2'b00;

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_o || reg_re_o) |-> $stable(reg_addr_o));
endmodule

// File: tb/pair_serial_reg_slave_tb_top.sv
module s2b_lane #(
   parameter int DW = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic done,
   output int   n_chk,
   output int   n_bad
);
   localparam int AC = 9;
   localparam int DC = DW / 2;

   logic          req;
   logic [1:0]    sdi;
   logic          ack;
   logic [1:0]    sdo;
   logic [16:0]   addr;
   logic [DW-1:0] wdata;
   logic          we;
   logic          re;
   logic [DW-1:0] rdata;

   logic [DW-1:0] mem [32];
   logic [DW-1:0] ref_mem [32];

   pair_serial_reg_slave #(.DATA_W(DW), .ADDR_W(17)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .sdi_i       (sdi),
      .ack_o       (ack),
      .sdo_o       (sdo),
      .reg_addr_o  (addr),
      .reg_wdata_o (wdata),
      .reg_we_o    (we),
      .reg_re_o    (re),
      .reg_rdata_i (rdata)
   );

   assign rdata = mem[addr[4:0]];
   always @(posedge clk) if (we) mem[addr[4:0]] <= wdata;

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL w%0d %s actual=%0h expected=%0h", DW, tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [16:0] a, input logic [DW-1:0] d, input int hold);
      int we_n = 0, we_at = -1, re_n = 0, re_at = -1, ack_n = 0, ack_at = -1, sdo_bad = 0;
      logic [DW-1:0] got = '0;
      logic [DW-1:0] wd_seen = '0;
      logic [16:0]   a_seen = '0;
      logic [17:0]   astr;
      astr = {a, 1'b0};
      for (int k = 0; k < hold + DC + 6; k++) begin
         @(negedge clk);
         if (k > 0) begin
            if (we) begin we_n++; we_at = k; a_seen = addr; wd_seen = wdata; end
            if (re) begin re_n++; re_at = k; a_seen = addr; end
            if (ack) begin
               if (ack_n == 0) ack_at = k;
               if (ack_n < DC) got[2*ack_n +: 2] = sdo;
               ack_n++;
            end else if (sdo != 2'b00) sdo_bad++;
         end
         req = (k < hold);
         if (k >= hold)        sdi = 2'b00;
         else if (k < AC)      sdi = astr[2*k +: 2];
         else if (k < AC + DC) sdi = d[2*(k-AC) +: 2];
         else                  sdi = 2'b00;
      end
      chk(sdo_bad == 0, "R8 sdo idle while ack low", 64'(sdo_bad), 0);
      if (hold == AC + DC) begin
         chk(we_n == 1 && we_at == AC + DC, "R5 write strobe cycle", 64'(we_at), 64'(AC + DC));
         chk(wd_seen == d, "R5 write data", 64'(wd_seen), 64'(d));
         chk(a_seen == a, "R2 write address", 64'(a_seen), 64'(a));
         chk(ack_n == 1 && ack_at == AC + DC + 1, "R6 write ack", 64'(ack_n), 1);
         chk(re_n == 0, "R5 no read strobe on write", 64'(re_n), 0);
         ref_mem[a[4:0]] = d;
      end else if (hold == AC) begin
         chk(re_n == 1 && re_at == AC + 1, "R3 read strobe cycle", 64'(re_at), 64'(AC + 1));
         chk(a_seen == a, "R2 read address", 64'(a_seen), 64'(a));
         chk(ack_n == DC && ack_at == AC + 2, "R4 read ack window", 64'(ack_n), 64'(DC));
         chk(got == ref_mem[a[4:0]], "R4 read data", 64'(got), 64'(ref_mem[a[4:0]]));
         chk(we_n == 0, "R3 no write strobe on read", 64'(we_n), 0);
      end else begin
         chk(we_n == 0 && re_n == 0 && ack_n == 0, "R7 aborted request quiet",
             64'(we_n + re_n + ack_n), 0);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int v);
      logic [31:0] x;
      x = 32'(v) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
      return (DW == 8) ? DW'(v) : DW'(x);
   endfunction

   initial begin
      int n_sweep;
      logic [16:0] a;
      done  = 1'b0;
      n_chk = 0;
      n_bad = 0;
      req   = 1'b0;
      sdi   = 2'b00;
      wait (rst_n === 1'b1);
      @(negedge clk);
      // R1 reset state
      chk(!ack && sdo == 2'b00 && !we && !re, "R1 reset outputs",
          64'({ack, sdo, we, re}), 0);
      n_sweep = (DW == 8) ? 256 : 48;
      for (int v = 0; v < n_sweep; v++) begin
         a = 17'(v * 2731 + 5);
         xfer(a, pat(v), AC + DC);
         xfer(a, '0, AC);
      end
      // R2 highest address bit pattern
      xfer(17'h1FFFF, pat(7), AC + DC);
      xfer(17'h1FFFF, '0, AC);
      xfer(17'h10000, pat(9), AC + DC);
      xfer(17'h10000, '0, AC);
      // R7 every abort length, target value must survive
      xfer(17'h00006, pat(3), AC + DC);
      for (int h = 1; h < AC + DC; h++) begin
         if (h != AC) begin
            xfer(17'h00006, ~pat(3), h);
            xfer(17'h00006, '0, AC);
         end
      end
      done = 1'b1;
   end
endmodule

module pair_serial_reg_slave_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic done8, done32;
   int   c8, b8, c32, b32;

   always #10 clk = ~clk;

   s2b_lane #(.DW(8))  lane8_i  (.clk(clk), .rst_n(rst_n), .done(done8),  .n_chk(c8),  .n_bad(b8));
   s2b_lane #(.DW(32)) lane32_i (.clk(clk), .rst_n(rst_n), .done(done32), .n_chk(c32), .n_bad(b32));

   initial begin
      int cyc = 0;
      int wd  = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      while (!(done8 === 1'b1 && done32 === 1'b1) && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!(done8 === 1'b1 && done32 === 1'b1)) begin
         wd = 1;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", c8 + c32 + wd, b8 + b32 + wd);
      $finish;
   end
endmodule